// File: doc/BRIEF.md
# CAN Controller Interrupt Aggregator

This block gathers the event sources of a CAN controller into two interrupt request lines. The mailbox line collects per-mailbox transmit-complete and receive-complete events. The error line collects these events: abort acknowledge, denied mailbox write, wakeup, lost receive message, bus-off entry, error-passive entry, and the error-counter warning level. Every event lands in a sticky flag that software clears by writing 1 to its bit. Each flag has its own enable. Each line has a priority bit, and that bit steers the request to either the high-priority or the low-priority output wire.

The block detects the bus-off, error-passive and warning conditions on their rising edge. The warning condition is true when either error counter is at or above a parameterised level, 96 by default. The wakeup flag is set asynchronously, so the error request can come up while the clock is stopped. Software reaches the flags, enables and priority bits through a small word-addressed register port. Reads from this port are combinational.

Top module: `can_irq_router`

## Requirements
- R1: After reset, all flags, enables and priority bits are 0, and all four request outputs are low.
- R2: A one-cycle pulse on `tx_done_i[i]` or `rx_done_i[i]` sets mailbox flag bit i or bit 8+i, as read at address 0. The flag is visible on the cycle after the pulse edge.
- R3: A pulse on `abort_ack_i` sets error flag bit 0, and a pulse on `wr_denied_i` sets bit 1. A pulse on `rx_lost_i` sets bit 3. Error flags are read at address 1.
- R4: A pulse on `wake_i` sets error flag bit 2 without a clock edge. When that flag is enabled, it drives the error request even with the clock stopped.
- R5: Bus-off (bit 4) and error-passive (bit 5) flags are set on the rising edge of `busoff_i` or `passive_i`. Clearing a flag while its condition is still held leaves it clear.
- R6: The warning flag (bit 6) is set on the rising edge of (tec ≥ 96 or rec ≥ 96). A counter value of 95 does not set it, and clearing it while the condition holds leaves it clear.
- R7: Writing a word to address 0 or 1 clears each flag whose bit is 1 in that word. Flags whose bits are 0 keep their value.
- R8: If an event and a clear of the same flag occur in the same cycle, the flag ends up set.
- R9: The mailbox line is active when any mailbox flag whose enable is set is also set. Enables are at address 2, in the same layout as address 0. A set flag with its enable cleared raises no request.
- R10: The error line is active when any error flag whose enable is set is also set. The error enables are bits 6:0 of address 3.
- R11: Bit 16 of address 3 selects high priority for the mailbox line, and bit 17 does the same for the error line. Each active line drives only `_hi_o` when its bit is 1 and only `_lo_o` when its bit is 0.
- R12: Enables and priority bits read back at addresses 2 and 3 exactly as they were written, for the implemented bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_done_i | input | NUM_MBOX | Per-mailbox transmit-complete pulse |
| rx_done_i | input | NUM_MBOX | Per-mailbox receive-complete pulse |
| abort_ack_i | input | 1 | Transmission abort acknowledge pulse |
| wr_denied_i | input | 1 | Denied CPU mailbox write pulse |
| wake_i | input | 1 | Wakeup event, may arrive with the clock stopped |
| rx_lost_i | input | 1 | Unread message overwritten pulse |
| tec_i | input | CNT_W | Transmit error counter |
| rec_i | input | CNT_W | Receive error counter |
| busoff_i | input | 1 | Bus-off state level |
| passive_i | input | 1 | Error-passive state level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| mbx_hi_o | output | 1 | Mailbox request, high priority |
| mbx_lo_o | output | 1 | Mailbox request, low priority |
| err_hi_o | output | 1 | Error request, high priority |
| err_lo_o | output | 1 | Error request, low priority |

## Verification
The hardest situation to reach from the ports is a wakeup that arrives while the clock is stopped. The stimulus first enables the wakeup flag and steers the error line high. It then halts the bench clock at a low phase and pulses `wake_i` between edges. The flag and `err_hi_o` are then read with no edge present. The condition-edge rules are also awkward, because they need a flag cleared while its level input is still held. The bench holds bus-off, passive or a counter at the warning level across the clearing write and confirms the flag stays clear. A same-cycle receive pulse and clearing write covers the set-over-clear rule.

// File: rtl/can_irq_pkg.sv
// Package: register word addresses, error-flag bit positions and
// priority bit positions shared by the aggregator, its checker and bench.
package can_irq_pkg;
    typedef enum logic [1:0] {
        REG_MBX_FLAGS = 2'd0,
        REG_ERR_FLAGS = 2'd1,
        REG_MBX_EN    = 2'd2,
        REG_CFG       = 2'd3
    } reg_sel_e;

    localparam int ERR_ABORT = 0;
    localparam int ERR_DENY  = 1;
    localparam int ERR_WAKE  = 2;
    localparam int ERR_LOST  = 3;
    localparam int ERR_BOFF  = 4;
    localparam int ERR_PASS  = 5;
    localparam int ERR_WARN  = 6;
    localparam int ERR_NUM   = 7;

    localparam int RX_OFS        = 8;
    localparam int PRIO_MBX_BIT  = 16;
    localparam int PRIO_ERR_BIT  = 17;
    localparam int LINE_MBX      = 0;
    localparam int LINE_ERR      = 1;
    localparam int LINE_NUM      = 2;
endpackage

// File: rtl/can_irq_sticky.sv
// Module: bank of W sticky flags. Set has priority over clear.
// Assumes set_i and clr_i are synchronous to clk.
module can_irq_sticky #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    // Flag update: clear the selected bits, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else begin
            q_o <= (q_o & ~clr_i) | set_i;
        end
    end
endmodule

// File: rtl/can_irq_wake.sv
// Module: single wakeup flag. It is set asynchronously by wake_i, so it
// works with the clock stopped. Clear and reset are synchronous.
// Assumes wake_i is glitch-free; a held wake_i overrides the clear.
module can_irq_wake (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_i,
    input  logic clr_i,
    output logic q_o
);
    // Async set on wake, synchronous reset and write-1 clear otherwise.
    always_ff @(posedge clk or posedge wake_i) begin
        if (wake_i) begin
            q_o <= 1'b1;
        end else if (!rst_n) begin
            q_o <= 1'b0;
        end else if (clr_i) begin
            q_o <= 1'b0;
        end
    end
endmodule

// File: rtl/can_irq_cond.sv
// Module: turns the bus-off, error-passive and counter-warning levels into
// one-cycle pulses on their rising edges. The warning level is
// tec >= WARN_LEVEL or rec >= WARN_LEVEL. After reset, a condition that
// is already true counts as a rising edge.
module can_irq_cond #(
    parameter int CNT_W      = 8,
    parameter int WARN_LEVEL = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tec_i,
    input  logic [CNT_W-1:0] rec_i,
    input  logic             busoff_i,
    input  logic             passive_i,
    output logic             boff_rise_o,
    output logic             pass_rise_o,
    output logic             warn_rise_o
);
    localparam logic [CNT_W-1:0] WARN_CNT = CNT_W'(WARN_LEVEL);

    logic [2:0] lvl;
    logic [2:0] lvl_q;

    // Current levels: {warning, passive, bus-off}.
    always_comb begin
        lvl[0] = busoff_i;
        lvl[1] = passive_i;
        lvl[2] = (tec_i >= WARN_CNT) || (rec_i >= WARN_CNT);
    end

    // Remember last cycle's levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl;
        end
    end

    assign boff_rise_o = lvl[0] & ~lvl_q[0];
    assign pass_rise_o = lvl[1] & ~lvl_q[1];
    assign warn_rise_o = lvl[2] & ~lvl_q[2];
endmodule

// File: rtl/can_irq_route.sv
// Module: masks the flags of each line with their enables and steers each
// active line to its high or low request wire. Purely combinational.
module can_irq_route #(
    parameter int MW = 12,
    parameter int EW = 7
) (
    input  logic [MW-1:0] mbx_flags_i,
    input  logic [MW-1:0] mbx_en_i,
    input  logic [EW-1:0] err_flags_i,
    input  logic [EW-1:0] err_en_i,
    input  logic [1:0]    prio_i,
    output logic [1:0]    hi_o,
    output logic [1:0]    lo_o
);
    logic [1:0] line_any;

    // Per-line OR of enabled flags.
    always_comb begin
        line_any[0] = |(mbx_flags_i & mbx_en_i);
        line_any[1] = |(err_flags_i & err_en_i);
    end

    // Priority steering, one identical slice per line.
    for (genvar l = 0; l < 2; l++) begin : g_line
        assign hi_o[l] = line_any[l] &  prio_i[l];
        assign lo_o[l] = line_any[l] & ~prio_i[l];
    end
endmodule

// File: rtl/can_irq_router.sv
// Module: CAN interrupt aggregator top. Holds the sticky mailbox and error
// flags, the enables and the priority bits, and drives four request wires.
// Register map (word addresses): 0 mailbox flags (tx in [N-1:0],
// rx in [8+N-1:8], write 1 to clear), 1 error flags [6:0] (write 1 to
// clear), 2 mailbox enables (same layout as 0), 3 error enables [6:0]
// with the mailbox priority in bit 16 and the error priority in bit 17.
// Assumes NUM_MBOX <= 8 and DATA_W >= 18.
module can_irq_router
    import can_irq_pkg::*;
#(
    parameter int NUM_MBOX   = 6,
    parameter int CNT_W      = 8,
    parameter int WARN_LEVEL = 96,
    parameter int DATA_W     = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_MBOX-1:0] tx_done_i,
    input  logic [NUM_MBOX-1:0] rx_done_i,
    input  logic                abort_ack_i,
    input  logic                wr_denied_i,
    input  logic                wake_i,
    input  logic                rx_lost_i,
    input  logic [CNT_W-1:0]    tec_i,
    input  logic [CNT_W-1:0]    rec_i,
    input  logic                busoff_i,
    input  logic                passive_i,
    input  logic                reg_wr_i,
    input  logic [1:0]          reg_addr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    output logic                mbx_hi_o,
    output logic                mbx_lo_o,
    output logic                err_hi_o,
    output logic                err_lo_o
);
    localparam int MW = 2 * NUM_MBOX;

    reg_sel_e         sel;
    logic             wr_mflag, wr_eflag, wr_men, wr_cfg;
    logic [MW-1:0]    mbx_q, mbx_set, mbx_clr, wmask_mbx, men_q;
    logic [ERR_NUM-1:0] err_q, err_set, err_clr, een_q;
    logic [1:0]       prio_q;
    logic             boff_rise, pass_rise, warn_rise;
    logic [1:0]       req_hi, req_lo;
    logic             unused_wdata;

    assign sel = reg_sel_e'(reg_addr_i);

    // Decode write strobes per register.
    always_comb begin
        wr_mflag = reg_wr_i && (sel == REG_MBX_FLAGS);
        wr_eflag = reg_wr_i && (sel == REG_ERR_FLAGS);
        wr_men   = reg_wr_i && (sel == REG_MBX_EN);
        wr_cfg   = reg_wr_i && (sel == REG_CFG);
    end

    // Gather the mailbox field of the write word: {rx, tx}.
    assign wmask_mbx    = {reg_wdata_i[RX_OFS +: NUM_MBOX], reg_wdata_i[NUM_MBOX-1:0]};
    assign unused_wdata = ^reg_wdata_i;

    // Mailbox flag set and clear vectors.
    always_comb begin
        mbx_set = {rx_done_i, tx_done_i};
        mbx_clr = wr_mflag ? wmask_mbx : '0;
    end

    can_irq_sticky #(.W(MW)) u_mbx_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (mbx_set),
        .clr_i (mbx_clr),
        .q_o   (mbx_q)
    );

    can_irq_cond #(.CNT_W(CNT_W), .WARN_LEVEL(WARN_LEVEL)) u_cond (
        .clk         (clk),
        .rst_n       (rst_n),
        .tec_i       (tec_i),
        .rec_i       (rec_i),
        .busoff_i    (busoff_i),
        .passive_i   (passive_i),
        .boff_rise_o (boff_rise),
        .pass_rise_o (pass_rise),
        .warn_rise_o (warn_rise)
    );

    // Error event vector in flag-bit order, and its clear vector.
    always_comb begin
        err_set            = '0;
        err_set[ERR_ABORT] = abort_ack_i;
        err_set[ERR_DENY]  = wr_denied_i;
        err_set[ERR_WAKE]  = wake_i;
        err_set[ERR_LOST]  = rx_lost_i;
        err_set[ERR_BOFF]  = boff_rise;
        err_set[ERR_PASS]  = pass_rise;
        err_set[ERR_WARN]  = warn_rise;
        err_clr            = wr_eflag ? reg_wdata_i[ERR_NUM-1:0] : '0;
    end

    // One flag per error bit; the wakeup bit uses the async-set variant.
    for (genvar k = 0; k < ERR_NUM; k++) begin : g_err
        if (k == ERR_WAKE) begin : g_async
            can_irq_wake u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .wake_i (err_set[k]),
                .clr_i  (err_clr[k]),
                .q_o    (err_q[k])
            );
        end else begin : g_sync
            can_irq_sticky #(.W(1)) u_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (err_set[k]),
                .clr_i (err_clr[k]),
                .q_o   (err_q[k])
            );
        end
    end

    // Enable and priority registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            men_q  <= '0;
            een_q  <= '0;
            prio_q <= '0;
        end else begin
            if (wr_men) begin
                men_q <= wmask_mbx;
            end
            if (wr_cfg) begin
                een_q            <= reg_wdata_i[ERR_NUM-1:0];
                prio_q[LINE_MBX] <= reg_wdata_i[PRIO_MBX_BIT];
                prio_q[LINE_ERR] <= reg_wdata_i[PRIO_ERR_BIT];
            end
        end
    end

    // Read data multiplexer.
    always_comb begin
        reg_rdata_o = '0;
        case (sel)
            REG_MBX_FLAGS: begin
                reg_rdata_o[NUM_MBOX-1:0]        = mbx_q[NUM_MBOX-1:0];
                reg_rdata_o[RX_OFS +: NUM_MBOX]  = mbx_q[MW-1:NUM_MBOX];
            end
            REG_ERR_FLAGS: reg_rdata_o[ERR_NUM-1:0] = err_q;
            REG_MBX_EN: begin
                reg_rdata_o[NUM_MBOX-1:0]        = men_q[NUM_MBOX-1:0];
                reg_rdata_o[RX_OFS +: NUM_MBOX]  = men_q[MW-1:NUM_MBOX];
            end
            default: begin
                reg_rdata_o[ERR_NUM-1:0]  = een_q;
                reg_rdata_o[PRIO_MBX_BIT] = prio_q[LINE_MBX];
                reg_rdata_o[PRIO_ERR_BIT] = prio_q[LINE_ERR];
            end
        endcase
    end

    can_irq_route #(.MW(MW), .EW(ERR_NUM)) u_route (
        .mbx_flags_i (mbx_q),
        .mbx_en_i    (men_q),
        .err_flags_i (err_q),
        .err_en_i    (een_q),
        .prio_i      (prio_q),
        .hi_o        (req_hi),
        .lo_o        (req_lo)
    );

    assign mbx_hi_o = req_hi[LINE_MBX];
    assign mbx_lo_o = req_lo[LINE_MBX];
    assign err_hi_o = req_hi[LINE_ERR];
    assign err_lo_o = req_lo[LINE_ERR];
endmodule

// File: rtl/can_irq_router_chk.sv
// Checker: temporal properties of the interrupt aggregator, bound to the
// top module. It observes ports and the flag and enable state.
module can_irq_router_chk
    import can_irq_pkg::*;
#(
    parameter int NUM_MBOX   = 6,
    parameter int CNT_W      = 8,
    parameter int WARN_LEVEL = 96,
    parameter int DATA_W     = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_MBOX-1:0]   tx_done_i,
    input logic [NUM_MBOX-1:0]   rx_done_i,
    input logic [CNT_W-1:0]      tec_i,
    input logic [CNT_W-1:0]      rec_i,
    input logic                  busoff_i,
    input logic                  passive_i,
    input logic                  reg_wr_i,
    input logic [1:0]            reg_addr_i,
    input logic [DATA_W-1:0]     reg_wdata_i,
    input logic [2*NUM_MBOX-1:0] mbx_q,
    input logic [ERR_NUM-1:0]    err_q,
    input logic [ERR_NUM-1:0]    een_q,
    input logic                  mbx_hi_o,
    input logic                  mbx_lo_o,
    input logic                  err_hi_o,
    input logic                  err_lo_o
);
    logic warn_lvl;
    assign warn_lvl = (tec_i >= CNT_W'(WARN_LEVEL)) || (rec_i >= CNT_W'(WARN_LEVEL));

    for (genvar i = 0; i < NUM_MBOX; i++) begin : g_mbx
        // R2: a transmit pulse sets its flag on the next cycle.
        a_r2_tx_sets: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(tx_done_i[i])) |-> mbx_q[i]);
        // R8: a receive pulse sets its flag even if a clear arrived with it.
        a_r8_rx_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(rx_done_i[i])) |-> mbx_q[NUM_MBOX+i]);
        // R7: a set transmit flag stays set unless its bit was written with 1.
        a_r7_tx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(mbx_q[i]) &&
             !$past(reg_wr_i && reg_addr_i == 2'd0 && reg_wdata_i[i])) |-> mbx_q[i]);
    end

    // R5: rising bus-off and passive levels set their flags.
    a_r5_boff_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busoff_i) |=> err_q[ERR_BOFF]);
    a_r5_pass_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(passive_i) |=> err_q[ERR_PASS]);
    // R6: the warning flag follows the rising counter threshold.
    a_r6_warn_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warn_lvl) |=> err_q[ERR_WARN]);
    // R10: an enabled, set error flag keeps the error line active.
    a_r10_err_line: assert property (@(posedge clk) disable iff (!rst_n)
        (|(err_q & een_q)) |-> (err_hi_o || err_lo_o));
    // R11: each line drives only one of its two request wires.
    a_r11_one_wire: assert property (@(posedge clk) disable iff (!rst_n)
        !(mbx_hi_o && mbx_lo_o) && !(err_hi_o && err_lo_o));
endmodule

bind can_irq_router can_irq_router_chk #(
    .NUM_MBOX(NUM_MBOX), .CNT_W(CNT_W), .WARN_LEVEL(WARN_LEVEL), .DATA_W(DATA_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_done_i   (tx_done_i),
    .rx_done_i   (rx_done_i),
    .tec_i       (tec_i),
    .rec_i       (rec_i),
    .busoff_i    (busoff_i),
    .passive_i   (passive_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .mbx_q       (mbx_q),
    .err_q       (err_q),
    .een_q       (een_q),
    .mbx_hi_o    (mbx_hi_o),
    .mbx_lo_o    (mbx_lo_o),
    .err_hi_o    (err_hi_o),
    .err_lo_o    (err_lo_o)
);

// File: tb/can_irq_router_tb.sv
// Scoreboard bench for the interrupt aggregator. The driver pushes expected
// register values and request vectors {mbx_hi, mbx_lo, err_hi, err_lo};
// the monitor pops and compares them against the ports.
module can_irq_router_tb_top;
    localparam int N = 6;

    logic        clk = 1'b0;
    logic        clk_run = 1'b1;
    logic        rst_n;
    logic [N-1:0] tx_done, rx_done;
    logic        abort_ack, wr_denied, wake, rx_lost, busoff, passive;
    logic [7:0]  tec, rec;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        mbx_hi, mbx_lo, err_hi, err_lo;

    typedef struct {
        string       tag;
        logic [1:0]  addr;
        logic [31:0] data;
        logic [3:0]  irq;
    } item_t;

    item_t sb_q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    always #5 if (clk_run) clk = ~clk;

    can_irq_router dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_done_i   (tx_done),
        .rx_done_i   (rx_done),
        .abort_ack_i (abort_ack),
        .wr_denied_i (wr_denied),
        .wake_i      (wake),
        .rx_lost_i   (rx_lost),
        .tec_i       (tec),
        .rec_i       (rec),
        .busoff_i    (busoff),
        .passive_i   (passive),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .mbx_hi_o    (mbx_hi),
        .mbx_lo_o    (mbx_lo),
        .err_hi_o    (err_hi),
        .err_lo_o    (err_lo)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    // Driver: select the register, then queue the expectation.
    task automatic expect_state(input string tag, input logic [1:0] a,
                                input logic [31:0] d, input logic [3:0] irq);
        item_t it;
        reg_addr = a;
        #1;
        it.tag = tag; it.addr = a; it.data = d; it.irq = irq;
        sb_q.push_back(it);
        #1;
    endtask

    // Monitor: compare each queued item with the current outputs.
    initial begin
        forever begin
            item_t it;
            logic [3:0] got;
            wait (sb_q.size() > 0);
            it  = sb_q.pop_front();
            got = {mbx_hi, mbx_lo, err_hi, err_lo};
            n_vec++;
            if (reg_rdata !== it.data || got !== it.irq) begin
                n_bad++;
                $display("FAIL %s: addr %0d rdata %h exp %h, irq %b exp %b",
                         it.tag, it.addr, reg_rdata, it.data, got, it.irq);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got hang exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tx_done = '0; rx_done = '0; abort_ack = 0; wr_denied = 0;
        wake = 0; rx_lost = 0; busoff = 0; passive = 0; tec = 0; rec = 0;
        reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1: reset state
        expect_state("R1 mbx flags", 2'd0, 32'h0, 4'b0000);
        expect_state("R1 err flags", 2'd1, 32'h0, 4'b0000);
        expect_state("R1 mbx enables", 2'd2, 32'h0, 4'b0000);
        expect_state("R1 cfg", 2'd3, 32'h0, 4'b0000);

        // R2: tx2 and rx5 pulses; R9: not enabled, no request
        tx_done[2] = 1'b1; rx_done[5] = 1'b1;
        tick();
        tx_done = '0; rx_done = '0;
        expect_state("R2 tx2 rx5 flags", 2'd0, 32'h0000_2004, 4'b0000);

        // R9/R12: enable tx2, low priority
        wr(2'd2, 32'h0000_0004);
        expect_state("R12 mbx enable readback", 2'd2, 32'h0000_0004, 4'b0100);
        expect_state("R9 enabled tx2 raises mbx low", 2'd0, 32'h0000_2004, 4'b0100);

        // R11: mailbox high priority
        wr(2'd3, 32'h0001_0000);
        expect_state("R11 mbx steered high", 2'd3, 32'h0001_0000, 4'b1000);

        // R7: clear tx2 only; R9: rx5 disabled gives no request
        wr(2'd0, 32'h0000_0004);
        expect_state("R7 W1C keeps rx5", 2'd0, 32'h0000_2000, 4'b0000);

        // R8: rx5 event with clear in same cycle
        rx_done[5] = 1'b1;
        wr(2'd0, 32'h0000_2000);
        rx_done = '0;
        expect_state("R8 set beats clear", 2'd0, 32'h0000_2000, 4'b0000);
        wr(2'd0, 32'h0000_2000);
        expect_state("R7 rx5 cleared", 2'd0, 32'h0, 4'b0000);

        // R3: abort, denied, lost
        abort_ack = 1; wr_denied = 1; rx_lost = 1;
        tick();
        abort_ack = 0; wr_denied = 0; rx_lost = 0;
        expect_state("R3 error events", 2'd1, 32'h0000_000B, 4'b0000);

        // R10/R11: enable lost flag, low then high
        wr(2'd3, 32'h0001_0008);
        expect_state("R10 err line low", 2'd1, 32'h0000_000B, 4'b0001);
        wr(2'd3, 32'h0002_0008);
        expect_state("R11 err steered high", 2'd3, 32'h0002_0008, 4'b0010);
        wr(2'd1, 32'h0000_000B);
        expect_state("R7 error flags cleared", 2'd1, 32'h0, 4'b0000);

        // R6: warning threshold
        tec = 8'd95;
        tick();
        expect_state("R6 95 below warning", 2'd1, 32'h0, 4'b0000);
        rec = 8'd96;
        tick();
        expect_state("R6 rec 96 warns", 2'd1, 32'h0000_0040, 4'b0000);
        wr(2'd1, 32'h0000_0040);
        tick();
        expect_state("R6 held level no reset", 2'd1, 32'h0, 4'b0000);
        tec = 0; rec = 0;
        tick();
        tec = 8'd200;
        tick();
        expect_state("R6 tec 200 warns again", 2'd1, 32'h0000_0040, 4'b0000);
        tec = 0;
        wr(2'd1, 32'h0000_0040);

        // R5: bus-off and passive edges
        busoff = 1;
        tick();
        expect_state("R5 busoff entry", 2'd1, 32'h0000_0010, 4'b0000);
        wr(2'd1, 32'h0000_0010);
        tick();
        expect_state("R5 busoff held no reset", 2'd1, 32'h0, 4'b0000);
        passive = 1;
        tick();
        expect_state("R5 passive entry", 2'd1, 32'h0000_0020, 4'b0000);
        busoff = 0; passive = 0;
        wr(2'd1, 32'h0000_0020);
        expect_state("R5 passive cleared", 2'd1, 32'h0, 4'b0000);

        // R4: wakeup with clock stopped
        wr(2'd3, 32'h0002_0004);
        clk_run = 1'b0;
        #20;
        wake = 1'b1;
        #3;
        wake = 1'b0;
        #3;
        expect_state("R4 wake with clock stopped", 2'd1, 32'h0000_0004, 4'b0010);
        #20;
        clk_run = 1'b1;
        @(negedge clk);
        wr(2'd1, 32'h0000_0004);
        expect_state("R4 wake cleared", 2'd1, 32'h0, 4'b0000);

        #10;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule